// File: doc/BRIEF.md
# Tamper Status and Response Controller

This block guards a device against physical tampering. It watches a group of tamper pins and an oscillator-failure flag and keeps a two-bit status that software reads: 0 while nothing is enabled, 1 once at least one source is enabled (armed), and 2 after an event has been caught. When an event is caught, it raises a non-maskable interrupt request. If wake is enabled, it also raises a wake request. It issues a single-cycle command that tells the battery-backed memory which region to wipe.

Software sets the block up through one configuration write strobe. It acknowledges an event through a clear strobe. If the event came from an oscillator failure, the clear is held back until the clock switch to the backup low-frequency oscillator has finished. A clear that arrives early is remembered and applied once the switch-done input goes high. Each tamper pin passes through a two-flop synchronizer before its rising edge is detected.

The state machine has five states. `ST_OFF` (status 0), `ST_ARMED` (status 1), `ST_HIT` (status 2, event from a pin), `ST_HIT_OSC` (status 2, an oscillator failure is involved) and `ST_CLR_WAIT` (status 2, a clear is latched and waits for the clock switch). The transitions are:
- `ST_OFF` to `ST_ARMED` when any source is enabled (arm).
- `ST_ARMED` to `ST_OFF` when all sources are disabled (disarm).
- `ST_ARMED` to `ST_HIT` on a pin event (pin trip).
- `ST_ARMED` or `ST_HIT` to `ST_HIT_OSC` on an oscillator event (osc trip).
- `ST_HIT` to `ST_ARMED` on a clear (clear).
- `ST_HIT_OSC` to `ST_ARMED` on a clear with switch done high (clear).
- `ST_HIT_OSC` to `ST_CLR_WAIT` on a clear with switch done low (defer).
- `ST_CLR_WAIT` to `ST_ARMED` when switch done goes high (release).

Top module: `tamper_guard`

## Requirements
- R1: After reset, status reads 0, `nmi_req` and `wake_req` are 0 and no memory-clear pulse is issued. A configuration write with every source disabled leaves status at 0.
- R2: A configuration write that enables at least one source makes status read 1 from the second clock edge after the write edge. Writing all sources disabled while status is 1 returns it to 0 in the same way.
- R3: A rising edge on an enabled tamper pin sets status to 2 and `nmi_req` to 1 at the third clock edge after the pin changes (two synchronizer flops plus the edge detector). Edges on disabled pins have no effect.
- R4: A rising edge of `osc_fail` while the oscillator source is enabled sets status to 2 and `nmi_req` to 1 at the first clock edge. When the oscillator source is disabled, `osc_fail` has no effect.
- R5: `nmi_req` stays 1 while status is 2 until a clear is accepted. A clear of a pin-only event returns status to 1 and drops `nmi_req` at the clock edge that samples `clr_wr`.
- R6: `wake_req` rises together with `nmi_req` only when the wake-enable bit was set at the moment of the event. It falls when the event is cleared.
- R7: At the edge where status goes from 1 to 2, `mem_clr_valid` pulses for exactly one cycle with `mem_clr_region` carrying the region code: 01 lower half, 10 upper half, 11 all. Code 00 (none) issues no pulse.
- R8: Further events while status is 2 keep status at 2 and issue no further memory-clear pulse.
- R9: If an oscillator event happened since the last clear, a clear sampled while `clk_switch_done` is 0 is latched. Status stays 2 and `nmi_req` stays 1 until `clk_switch_done` is 1, and status reads 1 from the following edge. A clear sampled while `clk_switch_done` is 1 takes effect at once.
- R10: `clr_wr` while status is 0 or 1 has no effect on status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low cold power-on reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_pin_en | input | NPIN | Per-pin tamper enable |
| cfg_osc_en | input | 1 | Oscillator-failure source enable |
| cfg_wake_en | input | 1 | Wake request enable |
| cfg_region | input | 2 | Memory region to wipe on event (00 none, 01 lower, 10 upper, 11 all) |
| clr_wr | input | 1 | Clear strobe for a caught event |
| tamper_pin | input | NPIN | Asynchronous tamper pins |
| osc_fail | input | 1 | Oscillator-failure flag, synchronous |
| clk_switch_done | input | 1 | High once the backup clock switch has finished |
| status | output | 2 | 0 disabled, 1 armed, 2 triggered |
| nmi_req | output | 1 | Non-maskable interrupt request |
| wake_req | output | 1 | Wake request |
| mem_clr_valid | output | 1 | One-cycle memory-clear command |
| mem_clr_region | output | 2 | Region code carried with the command |

## Verification
The bench times pin events to the exact edge. A design with one synchronizer flop too few or too many shows status 2 a cycle early or late. It triggers a second event while status is 2 and counts the memory-clear pulses, which catches a design that wipes memory again on every trip. It issues a clear before the clock switch is done, both for a pure oscillator event and for a pin event followed by an oscillator event. A design that drops the latched clear, or applies it early, leaves status at 2 forever or returns it to 1 too soon. It also drives edges on disabled pins and an `osc_fail` that is not enabled, and strobes the clear while armed or off, where a wrongly gated design would change status.

// File: rtl/tg_pkg.sv
package tg_pkg;

    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_ARMED    = 3'd1,
        ST_HIT      = 3'd2,
        ST_HIT_OSC  = 3'd3,
        ST_CLR_WAIT = 3'd4
    } tg_state_e;

    localparam logic [1:0] RGN_NONE = 2'b00;
    localparam logic [1:0] RGN_LOW  = 2'b01;
    localparam logic [1:0] RGN_HIGH = 2'b10;
    localparam logic [1:0] RGN_ALL  = 2'b11;

    localparam logic [1:0] STAT_OFF   = 2'd0;
    localparam logic [1:0] STAT_ARMED = 2'd1;
    localparam logic [1:0] STAT_HIT   = 2'd2;

    function automatic logic is_trig(input tg_state_e s);
        return (s == ST_HIT) || (s == ST_HIT_OSC) || (s == ST_CLR_WAIT);
    endfunction

endpackage

// File: rtl/tg_pin_sync.sv
module tg_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_i};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/tg_event_qual.sv
module tg_event_qual #(
    parameter int NPIN   = 4,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pins_i,
    input  logic [NPIN-1:0] pin_en_i,
    input  logic            osc_fail_i,
    input  logic            osc_en_i,
    output logic            pin_evt_o,
    output logic            osc_evt_o
);

    logic [NPIN-1:0] rise;
    logic            osc_last_q;

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        tg_pin_sync #(.STAGES(STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pins_i[g]),
            .rise_o (rise[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) osc_last_q <= 1'b0;
        else        osc_last_q <= osc_fail_i;
    end

    assign pin_evt_o = |(rise & pin_en_i);
    assign osc_evt_o = osc_en_i & osc_fail_i & ~osc_last_q;

endmodule

// File: rtl/tg_cfg_regs.sv
module tg_cfg_regs #(
    parameter int NPIN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [NPIN-1:0] pin_en_i,
    input  logic            osc_en_i,
    input  logic            wake_en_i,
    input  logic [1:0]      region_i,
    output logic [NPIN-1:0] pin_en_o,
    output logic            osc_en_o,
    output logic            wake_en_o,
    output logic [1:0]      region_o,
    output logic            any_en_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_en_o  <= '0;
            osc_en_o  <= 1'b0;
            wake_en_o <= 1'b0;
            region_o  <= 2'b00;
        end else if (wr_i) begin
            pin_en_o  <= pin_en_i;
            osc_en_o  <= osc_en_i;
            wake_en_o <= wake_en_i;
            region_o  <= region_i;
        end
    end

    assign any_en_o = (|pin_en_o) | osc_en_o;

endmodule

// File: rtl/tg_status_fsm.sv
module tg_status_fsm
    import tg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       any_en_i,
    input  logic       pin_evt_i,
    input  logic       osc_evt_i,
    input  logic       clr_i,
    input  logic       switch_done_i,
    input  logic       wake_en_i,
    input  logic [1:0] region_i,
    output logic [1:0] status_o,
    output logic       nmi_o,
    output logic       wake_o,
    output logic       mclr_valid_o,
    output logic [1:0] mclr_region_o,
    output logic       defer_o
);

    tg_state_e state_q, state_d;
    logic      entering;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (any_en_i) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (osc_evt_i)      state_d = ST_HIT_OSC;
                else if (pin_evt_i) state_d = ST_HIT;
                else if (!any_en_i) state_d = ST_OFF;
            end
            ST_HIT: begin
                if (osc_evt_i)  state_d = ST_HIT_OSC;
                else if (clr_i) state_d = ST_ARMED;
            end
            ST_HIT_OSC: begin
                if (clr_i) state_d = switch_done_i ? ST_ARMED : ST_CLR_WAIT;
            end
            ST_CLR_WAIT: begin
                if (switch_done_i) state_d = ST_ARMED;
            end
            default: state_d = ST_OFF;
        endcase
    end

    assign entering = (state_q == ST_ARMED) && is_trig(state_d);

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mclr_valid_o  <= 1'b0;
            mclr_region_o <= RGN_NONE;
            wake_o        <= 1'b0;
        end else begin
            mclr_valid_o  <= entering && (region_i != RGN_NONE);
            mclr_region_o <= entering ? region_i : RGN_NONE;
            if (entering)              wake_o <= wake_en_i;
            else if (!is_trig(state_d)) wake_o <= 1'b0;
        end
    end

    // state-decoded outputs
    always_comb begin
        unique case (state_q)
            ST_OFF:   status_o = STAT_OFF;
            ST_ARMED: status_o = STAT_ARMED;
            default:  status_o = STAT_HIT;
        endcase
    end

    assign nmi_o   = is_trig(state_q);
    assign defer_o = (state_q == ST_HIT_OSC) || (state_q == ST_CLR_WAIT);

endmodule

// File: rtl/tamper_guard.sv
module tamper_guard #(
    parameter int NPIN        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [NPIN-1:0] cfg_pin_en,
    input  logic            cfg_osc_en,
    input  logic            cfg_wake_en,
    input  logic [1:0]      cfg_region,
    input  logic            clr_wr,
    input  logic [NPIN-1:0] tamper_pin,
    input  logic            osc_fail,
    input  logic            clk_switch_done,
    output logic [1:0]      status,
    output logic            nmi_req,
    output logic            wake_req,
    output logic            mem_clr_valid,
    output logic [1:0]      mem_clr_region
);

    logic [NPIN-1:0] pin_en_q;
    logic            osc_en_q;
    logic            wake_en_q;
    logic [1:0]      region_q;
    logic            any_en;
    logic            pin_evt;
    logic            osc_evt;
    logic            defer_q;

    tg_cfg_regs #(.NPIN(NPIN)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (cfg_wr),
        .pin_en_i  (cfg_pin_en),
        .osc_en_i  (cfg_osc_en),
        .wake_en_i (cfg_wake_en),
        .region_i  (cfg_region),
        .pin_en_o  (pin_en_q),
        .osc_en_o  (osc_en_q),
        .wake_en_o (wake_en_q),
        .region_o  (region_q),
        .any_en_o  (any_en)
    );

    tg_event_qual #(.NPIN(NPIN), .STAGES(SYNC_STAGES)) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins_i     (tamper_pin),
        .pin_en_i   (pin_en_q),
        .osc_fail_i (osc_fail),
        .osc_en_i   (osc_en_q),
        .pin_evt_o  (pin_evt),
        .osc_evt_o  (osc_evt)
    );

    tg_status_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .any_en_i      (any_en),
        .pin_evt_i     (pin_evt),
        .osc_evt_i     (osc_evt),
        .clr_i         (clr_wr),
        .switch_done_i (clk_switch_done),
        .wake_en_i     (wake_en_q),
        .region_i      (region_q),
        .status_o      (status),
        .nmi_o         (nmi_req),
        .wake_o        (wake_req),
        .mclr_valid_o  (mem_clr_valid),
        .mclr_region_o (mem_clr_region),
        .defer_o       (defer_q)
    );

endmodule

// File: rtl/tamper_guard_chk.sv
module tamper_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clr_wr,
    input logic       clk_switch_done,
    input logic [1:0] status,
    input logic       nmi_req,
    input logic       wake_req,
    input logic       mem_clr_valid,
    input logic       defer_q
);

    assert_status_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'd3);

    assert_no_skip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd0) |=> (status != 2'd2));

    assert_nmi_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && !clr_wr && !clk_switch_done) |=> nmi_req);

    assert_nmi_matches_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req == (status == 2'd2));

    assert_wake_needs_nmi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> nmi_req);

    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_clr_valid |=> !mem_clr_valid);

    assert_pulse_on_trip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_clr_valid |-> (status == 2'd2) && ($past(status) == 2'd1));

    assert_clear_deferred_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (defer_q && clr_wr && !clk_switch_done) |=> (status == 2'd2));

endmodule

bind tamper_guard tamper_guard_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .clr_wr          (clr_wr),
    .clk_switch_done (clk_switch_done),
    .status          (status),
    .nmi_req         (nmi_req),
    .wake_req        (wake_req),
    .mem_clr_valid   (mem_clr_valid),
    .defer_q         (defer_q)
);

// File: tb/tamper_guard_test.sv
`timescale 1ns/1ps
module tamper_guard_test;

    localparam int NPIN = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            cfg_wr;
    logic [NPIN-1:0] cfg_pin_en;
    logic            cfg_osc_en;
    logic            cfg_wake_en;
    logic [1:0]      cfg_region;
    logic            clr_wr;
    logic [NPIN-1:0] tamper_pin;
    logic            osc_fail;
    logic            clk_switch_done;
    logic [1:0]      status;
    logic            nmi_req;
    logic            wake_req;
    logic            mem_clr_valid;
    logic [1:0]      mem_clr_region;

    int checks = 0;
    int errors = 0;
    int pulse_cnt = 0;
    logic [1:0] last_rgn = 2'b00;

    always #10 clk = ~clk;

    tamper_guard #(.NPIN(NPIN)) uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_wr          (cfg_wr),
        .cfg_pin_en      (cfg_pin_en),
        .cfg_osc_en      (cfg_osc_en),
        .cfg_wake_en     (cfg_wake_en),
        .cfg_region      (cfg_region),
        .clr_wr          (clr_wr),
        .tamper_pin      (tamper_pin),
        .osc_fail        (osc_fail),
        .clk_switch_done (clk_switch_done),
        .status          (status),
        .nmi_req         (nmi_req),
        .wake_req        (wake_req),
        .mem_clr_valid   (mem_clr_valid),
        .mem_clr_region  (mem_clr_region)
    );

    always @(negedge clk) begin
        if (mem_clr_valid) begin
            pulse_cnt = pulse_cnt + 1;
            last_rgn  = mem_clr_region;
        end
    end

    typedef struct packed {
        logic [3:0] pin_en;
        logic       osc_en;
        logic       wake_en;
        logic [1:0] region;
        logic [3:0] pins;
        logic       osc;
        logic [1:0] exp_stat;
        logic [1:0] exp_pulses;
        logic       exp_wake;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{4'b0001, 1'b0, 1'b1, 2'b11, 4'b0001, 1'b0, 2'd2, 2'd1, 1'b1},
        '{4'b0010, 1'b0, 1'b0, 2'b01, 4'b0001, 1'b0, 2'd1, 2'd0, 1'b0},
        '{4'b0000, 1'b1, 1'b1, 2'b10, 4'b0000, 1'b1, 2'd2, 2'd1, 1'b1},
        '{4'b1000, 1'b0, 1'b0, 2'b11, 4'b0000, 1'b1, 2'd1, 2'd0, 1'b0},
        '{4'b1111, 1'b0, 1'b1, 2'b00, 4'b1010, 1'b0, 2'd2, 2'd0, 1'b1},
        '{4'b0100, 1'b0, 1'b0, 2'b01, 4'b0100, 1'b0, 2'd2, 2'd1, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_pin_en = '0; cfg_osc_en = 1'b0;
        cfg_wake_en = 1'b0; cfg_region = 2'b00; clr_wr = 1'b0;
        tamper_pin = '0; osc_fail = 1'b0; clk_switch_done = 1'b1;
        wait_n(2);
        rst_n = 1'b1;
        wait_n(1);
    endtask

    task automatic configure(input logic [3:0] pe, input logic oe, input logic we, input logic [1:0] rg);
        cfg_pin_en = pe; cfg_osc_en = oe; cfg_wake_en = we; cfg_region = rg;
        cfg_wr = 1'b1;
        wait_n(1);
        cfg_wr = 1'b0;
        wait_n(1);
    endtask

    task automatic clear_pulse();
        clr_wr = 1'b1;
        wait_n(1);
        clr_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;

        // R1: reset state
        do_reset();
        chk(status == 2'd0, "R1 status after reset", status, 0);
        chk(!nmi_req && !wake_req, "R1 nmi/wake after reset", {nmi_req, wake_req}, 0);
        chk(pulse_cnt == 0, "R1 no clear pulse", pulse_cnt, 0);
        configure(4'b0000, 1'b0, 1'b1, 2'b11);
        wait_n(1);
        chk(status == 2'd0, "R1 all disabled stays off", status, 0);
        clear_pulse(); wait_n(1);
        chk(status == 2'd0, "R10 clear while off", status, 0);

        // R2: arm and disarm
        configure(4'b0001, 1'b0, 1'b0, 2'b00);
        chk(status == 2'd1, "R2 armed", status, 1);
        clear_pulse(); wait_n(1);
        chk(status == 2'd1, "R10 clear while armed", status, 1);
        configure(4'b0000, 1'b0, 1'b0, 2'b00);
        chk(status == 2'd0, "R2 disarmed", status, 0);

        // table walk: R3 R4 R6 R7
        for (int i = 0; i < 6; i++) begin
            do_reset();
            configure(VECS[i].pin_en, VECS[i].osc_en, VECS[i].wake_en, VECS[i].region);
            chk(status == 2'd1, "R2 vector armed", status, 1);
            base = pulse_cnt;
            tamper_pin = VECS[i].pins;
            osc_fail   = VECS[i].osc;
            wait_n(5);
            chk(status == VECS[i].exp_stat, "R3 R4 vector status", status, VECS[i].exp_stat);
            chk(nmi_req == (VECS[i].exp_stat == 2'd2), "R5 vector nmi", nmi_req, VECS[i].exp_stat == 2'd2);
            chk(wake_req == VECS[i].exp_wake, "R6 vector wake", wake_req, VECS[i].exp_wake);
            chk(pulse_cnt - base == VECS[i].exp_pulses, "R7 vector pulse count", pulse_cnt - base, VECS[i].exp_pulses);
            if (VECS[i].exp_pulses != 0)
                chk(last_rgn == VECS[i].region, "R7 vector region", last_rgn, VECS[i].region);
        end

        // R3 exact latency, R7 pulse width
        do_reset();
        configure(4'b0001, 1'b0, 1'b1, 2'b01);
        base = pulse_cnt;
        tamper_pin = 4'b0001;
        wait_n(2);
        chk(status == 2'd1, "R3 not yet after two edges", status, 1);
        wait_n(1);
        chk(status == 2'd2, "R3 triggered at third edge", status, 2);
        chk(mem_clr_valid && mem_clr_region == 2'b01, "R7 pulse with region", {mem_clr_valid, mem_clr_region}, 3'b101);
        wait_n(1);
        chk(!mem_clr_valid, "R7 pulse one cycle", mem_clr_valid, 0);

        // R8 second event: no second pulse
        configure(4'b0011, 1'b0, 1'b1, 2'b01);
        tamper_pin = 4'b0011;
        wait_n(5);
        chk(status == 2'd2, "R8 stays triggered", status, 2);
        chk(pulse_cnt - base == 1, "R8 no re-pulse", pulse_cnt - base, 1);

        // R5 nmi held, clear; R6 wake drops
        wait_n(10);
        chk(nmi_req && wake_req, "R5 R6 held before clear", {nmi_req, wake_req}, 3);
        clear_pulse();
        chk(status == 2'd1 && !nmi_req, "R5 cleared", status, 1);
        chk(!wake_req, "R6 wake cleared", wake_req, 0);

        // R4 R9 deferred clear after oscillator failure
        do_reset();
        configure(4'b0000, 1'b1, 1'b0, 2'b10);
        clk_switch_done = 1'b0;
        osc_fail = 1'b1;
        wait_n(1);
        chk(status == 2'd2, "R4 osc trip first edge", status, 2);
        chk(mem_clr_valid && mem_clr_region == 2'b10, "R7 osc pulse region", {mem_clr_valid, mem_clr_region}, 3'b110);
        osc_fail = 1'b0;
        clear_pulse();
        wait_n(3);
        chk(status == 2'd2 && nmi_req, "R9 clear held while switching", status, 2);
        clk_switch_done = 1'b1;
        wait_n(1);
        chk(status == 2'd1 && !nmi_req, "R9 latched clear applied", status, 1);

        // R9 clear with switch already done
        osc_fail = 1'b1;
        wait_n(1);
        osc_fail = 1'b0;
        chk(status == 2'd2, "R4 second osc trip", status, 2);
        clear_pulse();
        chk(status == 2'd1, "R9 immediate clear when done", status, 1);

        // R9 pin event followed by oscillator event
        do_reset();
        configure(4'b0001, 1'b1, 1'b0, 2'b11);
        base = pulse_cnt;
        clk_switch_done = 1'b0;
        tamper_pin = 4'b0001;
        wait_n(4);
        osc_fail = 1'b1;
        wait_n(1);
        osc_fail = 1'b0;
        clear_pulse();
        wait_n(2);
        chk(status == 2'd2, "R9 pin then osc defers clear", status, 2);
        chk(pulse_cnt - base == 1, "R8 osc after pin no re-pulse", pulse_cnt - base, 1);
        clk_switch_done = 1'b1;
        wait_n(1);
        chk(status == 2'd1, "R9 released after switch", status, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule